// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block connects two parameterised data buses, side A and side B, through two independent storage paths. One path carries A to B and the other carries B to A. Each path has its own mode input and its own path clock. With the mode input high the path is transparent: the destination output follows the source one system cycle later. With the mode input low the path holds its value, except that a rising edge on the path clock loads a fresh copy of the source. The path clocks and mode inputs are ordinary data signals here. The block samples them on a single fast system clock and finds edges by comparing two consecutive samples.

Each bus side is presented as three signals: an input value, a flag that says an outside agent is driving the line, and the block's own output value with its enable flag. The enable for side B is active high. The enable for side A is active low. Each side keeps a bus-hold register that remembers the last value on the line, so an undriven line feeds a defined value into the path. When the block drives a side itself and nothing outside does, the block's own output is what that path sees as its source.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While a path's mode input is high, that path's output equals the source line value of the previous system cycle.
- R2: While a path's mode input is low and its path clock shows no 0-to-1 change between two consecutive samples, the path's output does not change.
- R3: While a path's mode input is low, a path clock sampled 0 in one cycle and 1 in the next loads the source line value of that second cycle, which appears on the output after that system-clock edge.
- R4: The side-B enable flag `b_oe` equals the active-high input `ab_oe` delayed by one system cycle.
- R5: The side-A enable flag `a_oe` equals the inverse of the active-low input `ba_oe_n` delayed by one system cycle.
- R6: The B-to-A path follows R1 to R3 through `ba_le` and `ba_clk`, independently of the A-to-B path.
- R7: When no one drives a side (its external-drive flag is 0 and its enable flag is 0), that side's source line equals the last value seen on the line while it was driven.
- R8: The stored values keep updating while the enable flags are 0.
- R9: A synchronous active-high `rst` clears both stored values and both bus-hold registers to 0 and clears both enable flags. The previous-sample register of each path clock resets to 1, so a path clock that is already high when reset ends causes no load.
- R10: On a side where the block's enable flag is 1, the source line is the block's own output when the external-drive flag is 0, and the external input value when the external-drive flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_oe | input | 1 | Side-B output enable, active high |
| ba_oe_n | input | 1 | Side-A output enable, active low |
| ab_le | input | 1 | A-to-B mode: 1 transparent, 0 hold/edge |
| ba_le | input | 1 | B-to-A mode: 1 transparent, 0 hold/edge |
| ab_clk | input | 1 | A-to-B path clock, sampled |
| ba_clk | input | 1 | B-to-A path clock, sampled |
| a_in | input | W | Value an external agent places on side A |
| a_drv_ext | input | 1 | External agent is driving side A |
| a_out | output | W | Value the block drives onto side A |
| a_oe | output | 1 | Block drives side A |
| b_in | input | W | Value an external agent places on side B |
| b_drv_ext | input | 1 | External agent is driving side B |
| b_out | output | W | Value the block drives onto side B |
| b_oe | output | 1 | Block drives side B |

## Verification
The assertions assume that every control and data input is a clean synchronous signal that settles between system-clock edges. They also assume that a path clock is a level whose edges matter only through its sampled history. A clock pulse shorter than one system cycle is outside the checked behaviour. The stimulus changes inputs only on the falling system-clock edge, holds each path clock for at least one full cycle, and runs every path-clock rising edge with the mode input low. Before each load, the path clock is taken low while the mode input is already low, so the held value after leaving transparent mode is well defined.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_PASS = 2'd1,
        MODE_EDGE = 2'd2
    } path_mode_e;

    // Chooses how a storage path updates this cycle.
    function automatic path_mode_e pick_mode(input logic le,
                                             input logic pclk,
                                             input logic pclk_prev);
        if (le)
            return MODE_PASS;
        else if (pclk && !pclk_prev)
            return MODE_EDGE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_hold.sv
module xcvr_hold #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ext_drv,
    input  logic [W-1:0] ext_val,
    input  logic         own_drv,
    input  logic [W-1:0] own_val,
    output logic [W-1:0] line_val
);

    typedef struct packed {
        logic [W-1:0] hold;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     driven;

    always_comb begin
        driven = ext_drv || own_drv;
        // outside agent wins over the block's own driver
        if (ext_drv)
            line_val = ext_val;
        else if (own_drv)
            line_val = own_val;
        else
            line_val = st_q.hold;

        st_d = st_q;
        if (driven)
            st_d.hold = line_val;
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assert_hold_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (!ext_drv && !own_drv) |=> (st_q.hold == $past(st_q.hold)));

    assert_hold_track_R7: assert property (@(posedge clk) disable iff (rst)
        (ext_drv || own_drv) |=> (st_q.hold == $past(line_val)));

    assert_ext_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (ext_drv && own_drv) |-> (line_val == ext_val));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic         pclk,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic         pclk_prev;
        logic [W-1:0] store;
    } path_st_t;

    path_st_t   st_d, st_q;
    path_mode_e mode;

    always_comb begin
        mode = pick_mode(le, pclk, st_q.pclk_prev);
        st_d = st_q;
        st_d.pclk_prev = pclk;
        if (mode != MODE_HOLD)
            st_d.store = din;
        if (rst) begin
            st_d.pclk_prev = 1'b1;
            st_d.store     = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.store;

    assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
        le |=> (q == $past(din)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!le && !(pclk && !st_q.pclk_prev)) |=> $stable(q));

    assert_edge_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!le && pclk && !st_q.pclk_prev) |=> (q == $past(din)));

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ab_oe,
    input  logic         ba_oe_n,
    input  logic         ab_le,
    input  logic         ba_le,
    input  logic         ab_clk,
    input  logic         ba_clk,
    input  logic [W-1:0] a_in,
    input  logic         a_drv_ext,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    input  logic         b_drv_ext,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    localparam int NSIDE = 2;   // index 0 = side A / A-to-B path, 1 = side B / B-to-A path

    typedef struct packed {
        logic a_en;
        logic b_en;
    } oe_st_t;

    oe_st_t oe_d, oe_q;

    logic [NSIDE-1:0][W-1:0] ext_val, own_val, line_val, stored;
    logic [NSIDE-1:0]        ext_drv, own_drv, path_le, path_clk;

    always_comb begin
        oe_d.b_en = ab_oe;
        oe_d.a_en = !ba_oe_n;
        if (rst)
            oe_d = '0;
    end

    always_ff @(posedge clk) begin
        oe_q <= oe_d;
    end

    assign ext_val  = {b_in, a_in};
    assign ext_drv  = {b_drv_ext, a_drv_ext};
    assign own_drv  = {oe_q.b_en, oe_q.a_en};
    assign own_val  = {stored[0], stored[1]};
    assign path_le  = {ba_le, ab_le};
    assign path_clk = {ba_clk, ab_clk};

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        xcvr_hold #(.W(W)) u_hold (
            .clk      (clk),
            .rst      (rst),
            .ext_drv  (ext_drv[s]),
            .ext_val  (ext_val[s]),
            .own_drv  (own_drv[s]),
            .own_val  (own_val[s]),
            .line_val (line_val[s])
        );

        xcvr_path #(.W(W)) u_path (
            .clk  (clk),
            .rst  (rst),
            .le   (path_le[s]),
            .pclk (path_clk[s]),
            .din  (line_val[s]),
            .q    (stored[s])
        );
    end

    assign b_out = stored[0];
    assign a_out = stored[1];
    assign b_oe  = oe_q.b_en;
    assign a_oe  = oe_q.a_en;

    assert_b_en_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (b_oe == $past(ab_oe)));

    assert_a_en_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (a_oe == !$past(ba_oe_n)));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    assert_oe_off_update_R8: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !b_oe) |=> (b_out == $past(line_val[0])));

endmodule

// File: tb/dual_bus_xcvr_test.sv
`timescale 1ns/1ps
module dual_bus_xcvr_test;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic         ab_oe, ba_oe_n, ab_le, ba_le, ab_clk, ba_clk;
    logic [W-1:0] a_in, b_in;
    logic         a_drv_ext, b_drv_ext;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    dual_bus_xcvr #(.W(W)) uut (
        .clk(clk), .rst(rst), .ab_oe(ab_oe), .ba_oe_n(ba_oe_n),
        .ab_le(ab_le), .ba_le(ba_le), .ab_clk(ab_clk), .ba_clk(ba_clk),
        .a_in(a_in), .a_drv_ext(a_drv_ext), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_drv_ext(b_drv_ext), .b_out(b_out), .b_oe(b_oe)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [W-1:0] b;
        logic         boe;
        logic [W-1:0] a;
        logic         aoe;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // driver: push what the outputs must be after the coming edge
    task automatic step(input logic [W-1:0] eb, input logic ebe,
                        input logic [W-1:0] ea, input logic eae, input string tag);
        exp_t it;
        it.b = eb; it.boe = ebe; it.a = ea; it.aoe = eae; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    // monitor: pop and compare shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_chk += 4;
                if (b_out !== it.b) begin
                    n_bad++;
                    $display("FAIL %s b_out got %h exp %h", it.tag, b_out, it.b);
                end
                if (b_oe !== it.boe) begin
                    n_bad++;
                    $display("FAIL %s b_oe got %b exp %b", it.tag, b_oe, it.boe);
                end
                if (a_out !== it.a) begin
                    n_bad++;
                    $display("FAIL %s a_out got %h exp %h", it.tag, a_out, it.a);
                end
                if (a_oe !== it.aoe) begin
                    n_bad++;
                    $display("FAIL %s a_oe got %b exp %b", it.tag, a_oe, it.aoe);
                end
            end
        end
    end

    initial begin
        #(10 * 20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; ab_oe = 0; ba_oe_n = 1; ab_le = 0; ba_le = 0;
        ab_clk = 1; ba_clk = 0;
        a_drv_ext = 1; a_in = 18'h2AAAA;
        b_drv_ext = 0; b_in = '0;

        step('0, 0, '0, 0, "R9 reset cycle 1");
        step('0, 0, '0, 0, "R9 reset cycle 2");
        rst = 0;
        step('0, 0, '0, 0, "R9 path clock high at reset exit, no load");
        ab_clk = 0;
        step('0, 0, '0, 0, "R2 hold, clock falls");
        ab_clk = 1; a_in = 18'h15555;
        step(18'h15555, 0, '0, 0, "R3 rising path clock loads");
        a_in = 18'h00F0F;
        step(18'h15555, 0, '0, 0, "R2 clock steady high, hold");
        ab_le = 1; a_in = 18'h12345; ab_oe = 1;
        step(18'h12345, 1, '0, 0, "R1 R4 transparent, B enabled");
        a_in = 18'h0ABCD; ab_oe = 0;
        step(18'h0ABCD, 0, '0, 0, "R8 R4 update while B disabled");
        b_drv_ext = 1; b_in = 18'h3C3C3; ba_le = 1; ba_oe_n = 0;
        step(18'h0ABCD, 0, 18'h3C3C3, 1, "R5 R6 B-to-A transparent, A enabled");
        ba_le = 0; b_in = 18'h11111;
        step(18'h0ABCD, 0, 18'h3C3C3, 1, "R6 B-to-A hold");
        ba_clk = 1; ba_oe_n = 1; ab_le = 0; a_in = 18'h06060;
        step(18'h0ABCD, 0, 18'h11111, 0, "R6 R5 B-to-A edge load, A disabled");
        ab_le = 1; a_drv_ext = 0; a_in = 18'h3FFFF;
        step(18'h06060, 0, 18'h11111, 0, "R7 side A undriven uses held value");
        ba_oe_n = 0;
        step(18'h06060, 0, 18'h11111, 1, "R7 still undriven during enable delay");
        step(18'h11111, 0, 18'h11111, 1, "R10 own output feeds A-to-B path");
        a_drv_ext = 1; a_in = 18'h00777;
        step(18'h00777, 0, 18'h11111, 1, "R10 external driver wins");
        b_in = 18'h2D2D2;
        step(18'h00777, 0, 18'h11111, 1, "R2 B-to-A clock steady, hold");
        b_drv_ext = 0; b_in = '0; ba_le = 1;
        step(18'h00777, 0, 18'h2D2D2, 1, "R7 side B undriven uses held value");
        rst = 1;
        step('0, 0, '0, 0, "R9 reset mid-run");

        @(posedge clk);
        #5;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule